// File: doc/BRIEF.md
# Clock-Generator Configuration Slave on a Two-Wire Serial Bus

This block is a receive-and-read-back slave on a standard-mode two-wire serial bus (I2C, 100 kbit/s or slower, 8-bit bytes sent MSB first). It holds a small bank of control bytes for a clock generator and drives all of them out in parallel. The block has no register pointer. A host always writes from the first register upward and always reads the whole bank back.

Two fixed 8-bit address bytes are recognised, with the direction bit included in each: 0xD2 opens a write and 0xD3 opens a read. On a write, the two bytes that follow the address are a command code and a byte count. The block acknowledges both and then discards them. The data bytes after them fill register 0, register 1 and so on, one register per byte. On a read, the block first sends the number of registers and then each register in ascending order.

SCL and SDA reach the block already synchronised to the system clock. The block samples them at that clock rate and finds START and STOP conditions by watching SDA change while SCL is high. SDA is open-drain, so the block has only a pull-low enable for it.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address byte gets no ACK, and the data that follows it leaves every register unchanged.
- R2: On a write, the first two bytes after the address are acknowledged and have no effect on any register.
- R3: From the third byte after the address onward, data bytes are acknowledged and stored in register 0, then register 1, and so on up to register 5. Register i appears on `cfg_o[8*i+7:8*i]`.
- R4: A STOP after any complete byte ends the write. Registers written before it keep their new values and all other registers keep their old values.
- R5: Data bytes written after register 5 has been filled are still acknowledged but change nothing.
- R6: At reset the registers take the values reg0=0xE6, reg1=0x00, reg2=0x81, reg3=0xFF, reg4=0xFF, reg5=0x3C.
- R7: A read returns the count byte 0x06 first, then registers 0 to 5, each MSB first. Any byte requested after register 5 reads as 0xFF.
- R8: When the host answers a read byte with NACK, the slave releases SDA and sends nothing more until the next START.
- R9: A START, including a repeated START in the middle of a byte, restarts address matching. A STOP returns the slave to idle. In neither case does the byte that was cut off change any register.
- R10: The slave only pulls SDA low, and it changes SDA only while SCL is low. Bits from the host are sampled when SCL rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data level (wired bus value) |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |
| cfg_o | output | 48 | Register bank, register i in bits 8i+7..8i |

## Verification
The bench builds the block with its default parameters: six registers, addresses 0xD2 and 0xD3, and the reset pattern given in R6. This small configuration makes it practical to sweep all 256 address byte values and every write length from zero to eight data bytes. After each write, an overlong read returns the count, every register and the 0xFF filler, and these are compared against an arithmetic model. Directed cases cover early NACK, a repeated START after a full byte and one in the middle of a byte, and a write that stops after the command byte.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  // Protocol phases of the link controller
  typedef enum logic [2:0] {
    ST_IDLE,     // waiting for a START
    ST_ADDR,     // shifting in the address byte
    ST_WRX,      // shifting in a write byte
    ST_ACK_TX,   // slave acknowledge slot
    ST_RDX,      // shifting out a read byte
    ST_ACK_RX,   // host acknowledge slot
    ST_RD_NEXT   // host acked, load next byte on SCL fall
  } link_state_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/clkcfg_bus_cond.sv
module clkcfg_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q;
  logic sda_q;

  // Previous-sample registers; idle bus levels are high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // Edge and bus condition decode
  always_comb begin
    scl_rise  = scl_i & ~scl_q;
    scl_fall  = ~scl_i & scl_q;
    start_det = scl_i & scl_q & sda_q & ~sda_i;
    stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  end

endmodule

// File: rtl/clkcfg_link_fsm.sv
module clkcfg_link_fsm
  import clkcfg_pkg::*;
#(
  parameter logic [7:0] WR_ADDR  = 8'hD2,
  parameter logic [7:0] RD_ADDR  = 8'hD3,
  parameter int         NUM_REGS = 6,
  localparam int        IDX_W    = $clog2(NUM_REGS + 3),
  localparam int        SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              wr_en,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);

  // Header bytes discarded on a write, and index saturation points
  localparam int          HDR_BYTES = 2;
  localparam logic [IDX_W-1:0] WR_FIRST = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] WR_SAT   = IDX_W'(NUM_REGS + HDR_BYTES);
  localparam logic [IDX_W-1:0] RD_SAT   = IDX_W'(NUM_REGS + 1);

  link_state_e       state_q, state_d;
  logic [2:0]        bit_q, bit_d;
  logic [6:0]        shift_q, shift_d;
  logic [7:0]        tx_q, tx_d;
  logic              rd_mode_q, rd_mode_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              oe_q, oe_d;
  logic [7:0]        rx_byte;

  assign rx_byte = {shift_q, sda_i};

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    bit_d     = bit_q;
    shift_d   = shift_q;
    tx_d      = tx_q;
    rd_mode_d = rd_mode_q;
    idx_d     = idx_q;
    oe_d      = oe_q;
    wr_en     = 1'b0;
    wr_sel    = SEL_W'(idx_q - WR_FIRST);
    wr_data   = rx_byte;

    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      bit_d   = 3'd0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            shift_d = rx_byte[6:0];
            bit_d   = bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              if (rx_byte == WR_ADDR || rx_byte == RD_ADDR) begin
                state_d   = ST_ACK_TX;
                rd_mode_d = (rx_byte == RD_ADDR);
                idx_d     = '0;
              end else begin
                state_d = ST_IDLE;
              end
            end
          end
        end
        ST_WRX: begin
          if (scl_rise) begin
            shift_d = rx_byte[6:0];
            bit_d   = bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              state_d = ST_ACK_TX;
              if (idx_q >= WR_FIRST && idx_q < WR_SAT) begin
                wr_en = 1'b1;
              end
              if (idx_q != WR_SAT) begin
                idx_d = idx_q + IDX_W'(1);
              end
            end
          end
        end
        ST_ACK_TX: begin
          if (scl_fall) begin
            if (!oe_q) begin
              oe_d = 1'b1;
            end else begin
              bit_d = 3'd0;
              if (rd_mode_q) begin
                tx_d    = rd_byte;
                oe_d    = ~rd_byte[7];
                state_d = ST_RDX;
                if (idx_q != RD_SAT) begin
                  idx_d = idx_q + IDX_W'(1);
                end
              end else begin
                oe_d    = 1'b0;
                state_d = ST_WRX;
              end
            end
          end
        end
        ST_RDX: begin
          if (scl_rise) begin
            bit_d = bit_q + 3'd1;
          end else if (scl_fall) begin
            if (bit_q == 3'd0) begin
              oe_d    = 1'b0;
              state_d = ST_ACK_RX;
            end else begin
              oe_d = ~tx_q[3'd7 - bit_q];
            end
          end
        end
        ST_ACK_RX: begin
          if (scl_rise) begin
            state_d = sda_i ? ST_IDLE : ST_RD_NEXT;
          end
        end
        ST_RD_NEXT: begin
          if (scl_fall) begin
            tx_d    = rd_byte;
            oe_d    = ~rd_byte[7];
            bit_d   = 3'd0;
            state_d = ST_RDX;
            if (idx_q != RD_SAT) begin
              idx_d = idx_q + IDX_W'(1);
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_q     <= 3'd0;
      shift_q   <= 7'd0;
      tx_q      <= 8'd0;
      rd_mode_q <= 1'b0;
      idx_q     <= '0;
      oe_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      bit_q     <= bit_d;
      shift_q   <= shift_d;
      tx_q      <= tx_d;
      rd_mode_q <= rd_mode_d;
      idx_q     <= idx_d;
      oe_q      <= oe_d;
    end
  end

  assign rd_idx = idx_q;
  assign sda_oe = oe_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !oe_q); // R8
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !$past(scl_i)); // R10
  AST_WRITE_ONLY_IN_WRITE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_mode_q); // R3
  AST_STOP_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !oe_q)); // R9

endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
  import clkcfg_pkg::*;
#(
  parameter int                        NUM_REGS    = 6,
  parameter logic [NUM_REGS*BYTE_W-1:0] RESET_VALUE = '0,
  localparam int                       IDX_W       = $clog2(NUM_REGS + 3),
  localparam int                       SEL_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [BYTE_W-1:0]          rd_byte,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

  localparam logic [BYTE_W-1:0] COUNT_BYTE = BYTE_W'(NUM_REGS);
  localparam logic [BYTE_W-1:0] FILL_BYTE  = '1;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic              load;
    logic [BYTE_W-1:0] val_q;

    assign load = wr_en && (wr_sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= RESET_VALUE[BYTE_W*g +: BYTE_W];
      end else if (load) begin
        val_q <= wr_data;
      end
    end

    assign cfg_o[BYTE_W*g +: BYTE_W] = val_q;
  end

  // Read-back selection: count, then registers, then filler
  always_comb begin
    rd_byte = FILL_BYTE;
    if (rd_idx == '0) begin
      rd_byte = COUNT_BYTE;
    end
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i + 1)) begin
        rd_byte = cfg_o[BYTE_W*i +: BYTE_W];
      end
    end
  end

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(cfg_o)); // R4
  AST_WR_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_sel) < NUM_REGS)); // R5

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
  import clkcfg_pkg::*;
#(
  parameter logic [7:0]                 WR_ADDR     = 8'hD2,
  parameter logic [7:0]                 RD_ADDR     = 8'hD3,
  parameter int                         NUM_REGS    = 6,
  parameter logic [NUM_REGS*BYTE_W-1:0] RESET_VALUE = 48'h3CFFFF8100E6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

  localparam int IDX_W = $clog2(NUM_REGS + 3);
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [BYTE_W-1:0] rd_byte;
  logic [IDX_W-1:0]  rd_idx;
  logic              wr_en;
  logic [SEL_W-1:0]  wr_sel;
  logic [BYTE_W-1:0] wr_data;

  clkcfg_bus_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  clkcfg_link_fsm #(
    .WR_ADDR  (WR_ADDR),
    .RD_ADDR  (RD_ADDR),
    .NUM_REGS (NUM_REGS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_byte   (rd_byte),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  clkcfg_regfile #(
    .NUM_REGS    (NUM_REGS),
    .RESET_VALUE (RESET_VALUE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_byte (rd_byte),
    .cfg_o   (cfg_o)
  );

endmodule

// File: tb/clkcfg_i2c_slave_bench.sv
module clkcfg_i2c_slave_bench;

  localparam int          NREG = 6;
  localparam int          Q    = 6;
  localparam logic [47:0] DEF  = 48'h3CFFFF8100E6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        hsda = 1'b1;
  logic        sda_oe;
  logic [47:0] cfg;
  logic        sda_line;
  logic [7:0]  model [NREG];
  int          checks = 0;
  int          fails = 0;
  logic        prev_oe = 1'b0;
  logic        prev_scl = 1'b1;

  assign sda_line = hsda & ~sda_oe;

  always #4 clk = ~clk;

  clkcfg_i2c_slave u_clkcfg_i2c_slave (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe),
    .cfg_o  (cfg)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R10: SDA may only change while SCL was low
  always @(posedge clk) begin
    if (rst_n && (sda_oe !== prev_oe)) begin
      check("R10", "sda_oe changed with scl high", 64'(prev_scl), 64'd0);
    end
    prev_oe  = sda_oe;
    prev_scl = scl;
  end

  function automatic logic [47:0] model_flat();
    logic [47:0] v;
    for (int i = 0; i < NREG; i++) v[8*i +: 8] = model[i];
    return v;
  endfunction

  task automatic hw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    hsda = 1'b1; hw();
    scl  = 1'b1; hw();
    hsda = 1'b0; hw();
    scl  = 1'b0; hw();
  endtask

  task automatic bus_stop();
    hsda = 1'b0; hw();
    scl  = 1'b1; hw();
    hsda = 1'b1; hw();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      hsda = b[i]; hw();
      scl  = 1'b1; hw();
      scl  = 1'b0; hw();
    end
    hsda = 1'b1; hw();
    scl  = 1'b1; hw();
    acked = (sda_line == 1'b0);
    scl  = 1'b0; hw();
  endtask

  task automatic get_byte(input bit ack, output logic [7:0] b);
    hsda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw();
      scl  = 1'b1; hw();
      b[i] = sda_line;
      scl  = 1'b0;
    end
    hsda = ack ? 1'b0 : 1'b1; hw();
    scl  = 1'b1; hw();
    scl  = 1'b0; hw();
    hsda = 1'b1;
  endtask

  task automatic write_txn(input int n);
    bit ack;
    bus_start();
    put_byte(8'hD2, ack);  check("R1", "write address ack", 64'(ack), 64'd1);
    put_byte(8'hA5, ack);  check("R2", "command byte ack", 64'(ack), 64'd1);
    put_byte(8'h06, ack);  check("R2", "count byte ack", 64'(ack), 64'd1);
    for (int k = 0; k < n; k++) begin
      int v;
      v = n * 29 + k * 71 + 19;
      put_byte(8'(v), ack);
      if (k < NREG) begin
        check("R3", "data byte ack", 64'(ack), 64'd1);
        model[k] = 8'(v);
      end else begin
        check("R5", "extra byte ack", 64'(ack), 64'd1);
      end
    end
    bus_stop();
    check("R4", "registers after write", 64'(cfg), 64'(model_flat()));
  endtask

  task automatic read_txn(input int nbytes);
    bit         ack;
    logic [7:0] b;
    logic [7:0] exp;
    bus_start();
    put_byte(8'hD3, ack);  check("R1", "read address ack", 64'(ack), 64'd1);
    for (int j = 0; j < nbytes; j++) begin
      get_byte(j != nbytes - 1, b);
      if (j == 0)         exp = 8'h06;
      else if (j <= NREG) exp = model[j-1];
      else                exp = 8'hFF;
      check("R7", "read byte", 64'(b), 64'(exp));
    end
    check("R8", "sda released after nack", 64'(sda_oe), 64'd0);
    bus_stop();
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) model[i] = DEF[8*i +: 8];
    repeat (10) @(negedge clk);
    check("R6", "reset register values", 64'(cfg), 64'(DEF));
    check("R10", "sda released in reset", 64'(sda_oe), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6/R7: defaults read back
    read_txn(NREG + 1);

    // R1: every foreign address is ignored
    for (int a = 0; a < 256; a++) begin
      if (a != 8'hD2 && a != 8'hD3) begin
        bus_start();
        put_byte(8'(a), ack);
        bus_stop();
        check("R1", "foreign address nack", 64'(ack), 64'd0);
      end
    end
    bus_start();
    put_byte(8'hA4, ack);
    put_byte(8'h00, ack);
    put_byte(8'h06, ack);
    put_byte(8'h77, ack);
    bus_stop();
    check("R1", "foreign data leaves registers", 64'(cfg), 64'(model_flat()));

    // R3/R4/R5/R7: every write length, then overlong read
    for (int n = 0; n <= NREG + 2; n++) begin
      write_txn(n);
      read_txn(NREG + 3);
    end

    // R2: stop right after the command byte
    bus_start();
    put_byte(8'hD2, ack);
    put_byte(8'h5A, ack);
    check("R2", "lone command ack", 64'(ack), 64'd1);
    bus_stop();
    check("R2", "command byte has no effect", 64'(cfg), 64'(model_flat()));

    // R8: early NACK, then a normal read
    read_txn(2);
    read_txn(NREG + 1);

    // R9: repeated start after a full byte
    bus_start();
    put_byte(8'hD2, ack);
    put_byte(8'h00, ack);
    put_byte(8'h06, ack);
    put_byte(8'h5E, ack);
    model[0] = 8'h5E;
    bus_start();
    put_byte(8'hD3, ack);
    check("R9", "read address after repeated start", 64'(ack), 64'd1);
    get_byte(1'b1, b);
    check("R9", "count after repeated start", 64'(b), 64'h06);
    get_byte(1'b0, b);
    check("R9", "reg0 after repeated start", 64'(b), 64'h5E);
    bus_stop();

    // R9: repeated start in the middle of a data byte
    bus_start();
    put_byte(8'hD2, ack);
    put_byte(8'h00, ack);
    put_byte(8'h06, ack);
    for (int i = 0; i < 4; i++) begin
      hsda = i[0]; hw();
      scl  = 1'b1; hw();
      scl  = 1'b0; hw();
    end
    bus_start();
    put_byte(8'hD3, ack);
    check("R9", "read after mid-byte restart", 64'(ack), 64'd1);
    get_byte(1'b1, b);
    get_byte(1'b0, b);
    check("R9", "reg0 kept after mid-byte restart", 64'(b), 64'h5E);
    bus_stop();
    check("R9", "registers after aborted byte", 64'(cfg), 64'(model_flat()));

    repeat (10) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule